// File: doc/BRIEF.md
# VLAN Membership Table with Command Engine

This block holds one entry per VLAN ID (4096 with the default 12-bit ID) describing how the switch fabric treats that VLAN. Each entry has a valid flag, an independent-learning flag, a per-VLAN egress-tag enable, a port member bitmap, and a 2-bit egress-tag control for every port. Software does not address the table directly. It stages an entry image in two data words, then writes a command word that holds a start/busy flag, a function code and a VLAN ID. It polls the busy flag until it clears, then checks the invalid flag to see whether the command was accepted.

A read command copies the addressed entry into the data words. A write command stores the data words into the entry. Read-modify-write is therefore a read command, a software edit of the data words, and a write command. The register bus is a valid/ready address/data interface with combinational read data. A second, read-only lookup port serves the forwarding logic. It returns the valid flag and member bitmap of any VLAN ID one cycle after the ID is presented.

Top module: `vlan_cmd_table`

## Requirements
- R1: After reset, busy and invalid read 0, both data words read 0, and every VLAN ID looks up as not valid with an empty member bitmap.
- R2: The command word (address 0) reads back with busy at bit 31, invalid at bit 16, function code at bits 15:12 and VLAN ID at bits 11:0, and all other bits 0. A command write starts only if bit 31 of the written value is 1; otherwise the write has no effect. Starting a command clears invalid.
- R3: Data word 1 (address 1) keeps the independent-learning flag at bit 30, the egress-tag enable at bit 28, the member bitmap at bits 23:16 and the entry-valid flag at bit 0. All other bits read 0.
- R4: Function code 1 stores both data words into the entry of the command's VLAN ID. Busy reads 1 for exactly three polling cycles after the command write, and invalid is 0 on completion.
- R5: Function code 0 copies the addressed entry into both data words. Busy reads 1 for exactly three cycles, and invalid is 0 on completion.
- R6: Any function code other than 0 or 1 holds busy for one cycle only, then sets invalid and leaves the table unchanged.
- R7: While busy is 1, writes to the command word and to the data words are ignored.
- R8: The lookup port returns the valid flag and member bitmap of the presented VLAN ID on the clock edge after the ID is presented. It accepts a new ID every cycle, including ID 4095.
- R9: Writing an entry with both data words all zero invalidates it. Its lookup then returns not valid, and a read command returns zeros.
- R10: Data word 2 (address 2) holds a 2-bit egress-tag control for port p at bits 2p+1:2p (0 = untag, 2 = tag, 3 = stack behind a special header). Bits above the last port read 0, and the codes are returned unchanged by a write and read-back of the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 command, 1 data word 1, 2 data word 2 |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted (always 1) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| lk_vid | input | 12 | Lookup VLAN ID |
| lk_valid | output | 1 | Looked-up entry is valid |
| lk_members | output | 8 | Looked-up member bitmap |

## Verification
The bench counts busy polls for good and bad function codes. A design that finishes too early, or that treats an unknown code as a write, shows the wrong count or a changed lookup. It writes a new command and a data word while busy is set. A design that does not lock them out would retarget the command or store the wrong member bitmap. It also writes all-zero words, uses VLAN ID 4095 and sends lookups back to back. A stale valid bit, a truncated index or a lookup result off by one cycle would mismatch the scoreboard.

// File: rtl/vlan_cmd_table.sv
`timescale 1ns/1ps
module vlan_cmd_table #(
  parameter int NUM_PORTS  = 8,
  parameter int VID_W      = 12,
  parameter int CMD_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_valid,
  input  logic                 reg_write,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic                 reg_ready,
  output logic [31:0]          reg_rdata,
  input  logic [VID_W-1:0]     lk_vid,
  output logic                 lk_valid,
  output logic [NUM_PORTS-1:0] lk_members
);
  localparam int DEPTH = 1 << VID_W;
  localparam int CW    = $clog2(CMD_CYCLES) + 1;
  localparam logic [CW-1:0] LAST = CW'(CMD_CYCLES - 1);
  localparam logic [1:0] A_CMD = 2'd0, A_DW1 = 2'd1, A_DW2 = 2'd2;

  typedef struct packed {
    logic                   ivl;
    logic                   vtag;
    logic [NUM_PORTS-1:0]   members;
    logic                   valid;
    logic [2*NUM_PORTS-1:0] etag;
  } entry_t;

  logic             busy_q, inv_q;
  logic [3:0]       func_q;
  logic [VID_W-1:0] vid_q;
  logic [CW-1:0]    cnt_q;
  entry_t           dw_q, ent_rd, lk_ent;
  entry_t           tbl_q [DEPTH];
  logic [DEPTH-1:0] seen_q;
  logic             unused_bits;

  wire wr_any = reg_valid & reg_write & ~busy_q;
  wire cmd_go = wr_any && reg_addr == A_CMD && reg_wdata[31];
  wire fn_ok  = func_q[3:1] == 3'd0;
  wire done   = busy_q && cnt_q == '0;
  wire do_wr  = done && fn_ok && func_q[0];
  wire do_rd  = done && fn_ok && !func_q[0];

  assign reg_ready   = 1'b1;
  assign ent_rd      = seen_q[vid_q] ? tbl_q[vid_q] : '0;
  assign lk_ent      = tbl_q[lk_vid];
  assign unused_bits = ^{reg_wdata[29], reg_wdata[27:24]};

  always_ff @(posedge clk)
    if (do_wr) tbl_q[vid_q] <= dw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inv_q  <= 1'b0;
      func_q <= '0;
      vid_q  <= '0;
      cnt_q  <= '0;
    end else if (cmd_go) begin
      busy_q <= 1'b1;
      inv_q  <= 1'b0;
      func_q <= reg_wdata[15:12];
      vid_q  <= reg_wdata[VID_W-1:0];
      cnt_q  <= (reg_wdata[15:13] == 3'd0) ? LAST : '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        inv_q  <= !fn_ok;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dw_q   <= '0;
      seen_q <= '0;
    end else begin
      if (do_wr) seen_q[vid_q] <= 1'b1;
      if (do_rd) dw_q <= ent_rd;
      else if (wr_any && reg_addr == A_DW1) begin
        dw_q.ivl     <= reg_wdata[30];
        dw_q.vtag    <= reg_wdata[28];
        dw_q.members <= reg_wdata[16 +: NUM_PORTS];
        dw_q.valid   <= reg_wdata[0];
      end else if (wr_any && reg_addr == A_DW2) begin
        dw_q.etag <= reg_wdata[2*NUM_PORTS-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_valid   <= 1'b0;
      lk_members <= '0;
    end else begin
      lk_valid   <= seen_q[lk_vid] & lk_ent.valid;
      lk_members <= seen_q[lk_vid] ? lk_ent.members : '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD: begin
        reg_rdata[31]         = busy_q;
        reg_rdata[16]         = inv_q;
        reg_rdata[15:12]      = func_q;
        reg_rdata[VID_W-1:0]  = vid_q;
      end
      A_DW1: begin
        reg_rdata[30]               = dw_q.ivl;
        reg_rdata[28]               = dw_q.vtag;
        reg_rdata[16 +: NUM_PORTS]  = dw_q.members;
        reg_rdata[0]                = dw_q.valid;
      end
      A_DW2: reg_rdata[2*NUM_PORTS-1:0] = dw_q.etag;
      default: ;
    endcase
  end

  AST_START_CLEARS_INV: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_q) |-> !inv_q) else $error("start left invalid set"); // R2
  AST_BUSY_SECOND: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_q) && fn_ok |=> busy_q) else $error("busy too short"); // R4
  AST_BUSY_THIRD: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_q) && fn_ok |=> ##1 busy_q) else $error("busy too short"); // R5
  AST_GOOD_NO_INV: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_q) && fn_ok |-> !inv_q) else $error("good code flagged"); // R4
  AST_BAD_FUNC: assert property (@(posedge clk) disable iff (!rst_n) done && !fn_ok |=> inv_q && !busy_q && $stable(seen_q)) else $error("bad code mishandled"); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy_q && reg_valid && reg_write && reg_addr == A_CMD |=> $stable(vid_q) && $stable(func_q)) else $error("command taken while busy"); // R7
endmodule

// File: tb/vlan_cmd_table_tb_top.sv
`timescale 1ns/1ps
module vlan_cmd_table_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready;
  logic [31:0] reg_rdata;
  logic [11:0] lk_vid = '0;
  logic        lk_valid;
  logic [7:0]  lk_members;

  always #2.5 clk = ~clk;

  vlan_cmd_table dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
    .reg_rdata(reg_rdata), .lk_vid(lk_vid), .lk_valid(lk_valid),
    .lk_members(lk_members)
  );

  int checks = 0, fails = 0;
  longint cyc = 0;
  bit done_flag = 1'b0;
  bit       m_v   [4096];
  bit [7:0] m_mem [4096];
  logic [31:0] st_dw1 = '0;

  typedef struct { longint due; logic [8:0] exp; int vid; string req; } lk_item_t;
  lk_item_t sbq[$];

  always @(posedge clk) cyc++;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial forever begin
    lk_item_t it;
    @(negedge clk);
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      it = sbq.pop_front();
      chk(it.req, $sformatf("lookup vid %0d", it.vid), {23'b0, lk_valid, lk_members}, {23'b0, it.exp});
    end
  end

  task automatic lookup(int vid, string req);
    lk_item_t it;
    lk_vid = 12'(vid);
    it.due = cyc + 1; it.exp = {m_v[vid], m_mem[vid]}; it.vid = vid; it.req = req;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd1) st_dw1 = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  function automatic logic [31:0] cmdw(int func, int vid);
    return 32'h8000_0000 | (32'(func) << 12) | 32'(vid);
  endfunction

  task automatic run_cmd(int func, int vid, output int n);
    logic [31:0] v;
    reg_wr(2'd0, cmdw(func, vid));
    if (func == 1) begin m_v[vid] = st_dw1[0]; m_mem[vid] = st_dw1[23:16]; end
    n = 0;
    reg_rd(2'd0, v);
    while (v[31] && n < 20) begin n++; reg_rd(2'd0, v); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(2'd0, v); chk("R1", "cmd after reset", v, 32'h0);
    reg_rd(2'd1, v); chk("R1", "dw1 after reset", v, 32'h0);
    reg_rd(2'd2, v); chk("R1", "dw2 after reset", v, 32'h0);
    lookup(5, "R1"); lookup(4095, "R1");

    // R3 / R10 staging and field masking
    reg_wr(2'd1, 32'h5041_0021);
    reg_rd(2'd1, v); chk("R3", "dw1 fields", v, 32'h5041_0001);
    reg_wr(2'd2, 32'hFFFF_3008);
    reg_rd(2'd2, v); chk("R10", "dw2 egress codes", v, 32'h0000_3008);

    // R4 write command and busy duration
    run_cmd(1, 100, n); chk("R4", "write busy polls", n, 3);
    reg_rd(2'd0, v); chk("R2", "cmd readback", v, 32'h0000_1064);
    lookup(100, "R8"); lookup(101, "R8"); lookup(100, "R8");

    // R5 read command restores words
    reg_wr(2'd1, 32'h0); reg_wr(2'd2, 32'h0);
    run_cmd(0, 100, n); chk("R5", "read busy polls", n, 3);
    reg_rd(2'd1, v); chk("R5", "dw1 restored", v, 32'h5041_0001);
    reg_rd(2'd2, v); chk("R10", "etag read back", v, 32'h0000_3008);

    // R6 unknown function code
    reg_wr(2'd1, 32'h0);
    run_cmd(5, 100, n); chk("R6", "bad func busy polls", n, 1);
    reg_rd(2'd0, v); chk("R6", "invalid flag", v, 32'h0001_5064);
    lookup(100, "R6");
    run_cmd(0, 100, n);
    reg_rd(2'd1, v); chk("R6", "entry unchanged", v, 32'h5041_0001);
    reg_rd(2'd0, v); chk("R2", "invalid cleared by start", v, 32'h0000_0064);

    // R2 command write without start bit
    reg_wr(2'd0, 32'h0000_1222);
    reg_rd(2'd0, v); chk("R2", "no start bit ignored", v, 32'h0000_0064);

    // R7 writes while busy ignored
    reg_wr(2'd1, 32'h0003_0001);
    m_v[200] = 1'b1; m_mem[200] = 8'h03;
    reg_wr(2'd0, cmdw(1, 200));
    reg_wr(2'd0, cmdw(1, 300));
    reg_wr(2'd1, 32'h00F0_0001);
    n = 0; reg_rd(2'd0, v);
    while (v[31] && n < 20) begin n++; reg_rd(2'd0, v); end
    chk("R7", "cmd kept first vid", v, 32'h0000_10C8);
    reg_rd(2'd1, v); chk("R7", "dw1 busy write dropped", v, 32'h0003_0001);
    lookup(200, "R7"); lookup(300, "R7");

    // R9 zero write invalidates
    reg_wr(2'd1, 32'h0); reg_wr(2'd2, 32'h0);
    run_cmd(1, 100, n);
    lookup(100, "R9");
    reg_wr(2'd1, 32'h1000_0001);
    run_cmd(0, 100, n);
    reg_rd(2'd1, v); chk("R9", "read of cleared entry", v, 32'h0);

    // R8 boundary VID and back-to-back lookups
    reg_wr(2'd1, 32'h4080_0001); reg_wr(2'd2, 32'h0000_C000);
    run_cmd(1, 4095, n); chk("R4", "write vid 4095 polls", n, 3);
    reg_wr(2'd1, 32'h0); reg_wr(2'd2, 32'h0);
    run_cmd(0, 4095, n);
    reg_rd(2'd2, v); chk("R10", "port 7 stack code", v, 32'h0000_C000);
    lookup(4095, "R8"); lookup(0, "R8"); lookup(200, "R8"); lookup(4095, "R8"); lookup(100, "R8");

    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule